// File: doc/BRIEF.md
# Two-Pixel RGB Stream Gain Corrector

This block sits in a video stream that carries two RGB pixels on each beat. It multiplies every red, green and blue component by a gain for that colour channel. A processor supplies the three gains, for example to correct white balance. Each product is rescaled back to eight bits and clipped at full scale. The block then repacks the results into the output beat. The frame-start and line-end flags travel through the same registered pipeline as the pixel data, so they stay aligned with the data.

The sink's ready signal drives the whole pipeline. While the sink is not ready, nothing moves, and the source sees that same ready signal. New gain values take effect only at a frame boundary. The block samples its gain inputs when a frame-start beat is accepted, so every pixel of a frame is corrected with one set of gains, even if the processor rewrites the gains in the middle of the frame.

Top module: `rgbg_gain_stream`

## Requirements
- R1: After a synchronous active-low reset, `m_tvalid`, `m_tuser`, `m_tlast` and `m_tdata` are all zero, and the active gains of all three channels hold the unity value 32768.
- R2: `s_tready` equals `m_tready` in every cycle.
- R3: Pixel p (0 or 1) occupies bits [24p+23:24p] of both the input and the output word. Within a pixel, red is in bits [23:16], green in [15:8] and blue in [7:0].
- R4: Each output component equals floor(component × gain / 32768) for the active gain of its channel. A gain of 32768 passes the component through unchanged, and a gain of 0 gives 0.
- R5: A rescaled value above 255 is clipped to 255 and never wraps. This includes a component of 255 with the largest gain, 131071.
- R6: A beat presented while `m_tready` is 1 appears on the output after three cycles in which `m_tready` is 1. A beat with `s_tvalid` low passes through as an output beat with `m_tvalid` low.
- R7: In a cycle with `m_tready` low, none of the outputs and no pipeline state changes.
- R8: `m_tuser` and `m_tlast` leave the block on the same output beat as the data they entered with.
- R9: The gain inputs are sampled only on a beat with `s_tvalid`, `s_tuser` and `m_tready` all 1. That beat and all later beats use the sampled gains, and changes to the gain inputs at any other time have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gain_r | input | 17 | Red gain, unsigned, with 32768 as unity |
| gain_g | input | 17 | Green gain, unsigned, with 32768 as unity |
| gain_b | input | 17 | Blue gain, unsigned, with 32768 as unity |
| s_tdata | input | 48 | Input beat carrying two RGB pixels |
| s_tvalid | input | 1 | Input beat valid |
| s_tuser | input | 1 | Input frame-start flag |
| s_tlast | input | 1 | Input line-end flag |
| s_tready | output | 1 | Ready to the source |
| m_tdata | output | 48 | Corrected beat carrying two RGB pixels |
| m_tvalid | output | 1 | Output beat valid |
| m_tuser | output | 1 | Output frame-start flag |
| m_tlast | output | 1 | Output line-end flag |
| m_tready | input | 1 | Ready from the sink; enables the pipeline |

## Verification
The hardest case to reach from the ports is a frame-start beat that enters while the previous frame's beats are still in flight, combined with sink stalls. The gain change must then land on exactly the right beat. The stimulus reprograms the gains in the middle of a frame and just before a new frame. It runs these frames under random valid and ready gaps, so the gain switch happens with older beats still in the multiply and output stages. Separate frames drive full-scale components with the largest gain and with zero gain to reach both ends of the clipping range.

// File: rtl/rgbg_pkg.sv
// Package: shared constants for the two-pixel RGB gain corrector.
// Assumes three colour components per pixel with blue in the lowest slot.
package rgbg_pkg;
    localparam int CH_PER_PIX = 3;
    localparam int CH_B       = 0;
    localparam int CH_G       = 1;
    localparam int CH_R       = 2;
    localparam int SIDE_W     = 3;
    localparam int SIDE_VALID = 2;
    localparam int SIDE_USER  = 1;
    localparam int SIDE_LAST  = 0;
endpackage

// File: rtl/rgbg_coef_hold.sv
// Module: holds the active channel gains for the frame in progress.
// Assumes load pulses only when a frame-start beat is accepted; resets to unity.
module rgbg_coef_hold #(
    parameter int COEF_W = 17,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COEF_W-1:0] gain_r,
    input  logic [COEF_W-1:0] gain_g,
    input  logic [COEF_W-1:0] gain_b,
    output logic [COEF_W-1:0] coef_r,
    output logic [COEF_W-1:0] coef_g,
    output logic [COEF_W-1:0] coef_b
);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    // Capture new gains at a frame start, otherwise keep the current ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_r <= UNITY;
            coef_g <= UNITY;
            coef_b <= UNITY;
        end else if (load) begin
            coef_r <= gain_r;
            coef_g <= gain_g;
            coef_b <= gain_b;
        end
    end
endmodule

// File: rtl/rgbg_lane.sv
// Module: one colour lane with a registered multiply, then a registered rescale and clip.
// Assumes COEF_W > FRAC_W so that the rescaled value can exceed the component range.
module rgbg_lane #(
    parameter int COMP_W = 8,
    parameter int COEF_W = 17,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [COMP_W-1:0] comp_i,
    input  logic [COEF_W-1:0] coef_i,
    output logic [COMP_W-1:0] comp_o
);
    localparam int PROD_W = COMP_W + COEF_W;
    localparam int SCL_W  = PROD_W - FRAC_W;

    logic [PROD_W-1:0] prod_q;
    logic [SCL_W-1:0]  scaled;
    logic [COMP_W-1:0] clipped;

    // Product register directly after the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n)  prod_q <= '0;
        else if (en) prod_q <= PROD_W'(comp_i) * PROD_W'(coef_i);
    end

    // Drop the fraction bits and clip anything beyond full scale.
    always_comb begin
        scaled = prod_q[PROD_W-1:FRAC_W];
        if (|scaled[SCL_W-1:COMP_W]) clipped = '1;
        else                         clipped = scaled[COMP_W-1:0];
    end

    // Output register after the rescale.
    always_ff @(posedge clk) begin
        if (!rst_n)  comp_o <= '0;
        else if (en) comp_o <= clipped;
    end
endmodule

// File: rtl/rgbg_side_delay.sv
// Module: enable-gated delay line for the flag bits, matched to the data latency.
// Assumes DEPTH >= 1 and that the delay advances on the same enable as the data.
module rgbg_side_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] tap_q [DEPTH];

    // First tap takes the input.
    always_ff @(posedge clk) begin
        if (!rst_n)  tap_q[0] <= '0;
        else if (en) tap_q[0] <= d_i;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_tap
        // Each later tap takes its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n)  tap_q[k] <= '0;
            else if (en) tap_q[k] <= tap_q[k-1];
        end
    end

    assign d_o = tap_q[DEPTH-1];
endmodule

// File: rtl/rgbg_gain_stream.sv
// Module: per-channel gain corrector for a stream carrying several RGB pixels per beat.
// Pipeline: input register, product register, output register, all enabled by
// m_tready. The flag bits are delayed to match. Gains are latched at frame start.
module rgbg_gain_stream
    import rgbg_pkg::*;
#(
    parameter int PIX    = 2,
    parameter int COMP_W = 8,
    parameter int COEF_W = 17,
    parameter int FRAC_W = 15
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [COEF_W-1:0]               gain_r,
    input  logic [COEF_W-1:0]               gain_g,
    input  logic [COEF_W-1:0]               gain_b,
    input  logic [PIX*CH_PER_PIX*COMP_W-1:0] s_tdata,
    input  logic                            s_tvalid,
    input  logic                            s_tuser,
    input  logic                            s_tlast,
    output logic                            s_tready,
    output logic [PIX*CH_PER_PIX*COMP_W-1:0] m_tdata,
    output logic                            m_tvalid,
    output logic                            m_tuser,
    output logic                            m_tlast,
    input  logic                            m_tready
);
    localparam int LANES  = PIX * CH_PER_PIX;
    localparam int DATA_W = LANES * COMP_W;
    localparam int DEPTH  = 3;

    logic              en;
    logic              coef_load;
    logic [DATA_W-1:0] in_data_q;
    logic [COEF_W-1:0] coef_r, coef_g, coef_b;
    logic [COEF_W-1:0] coef_ch [CH_PER_PIX];
    logic [SIDE_W-1:0] side_in, side_out;

    assign en        = m_tready;
    assign s_tready  = m_tready;
    assign coef_load = s_tvalid & s_tuser & m_tready;

    rgbg_coef_hold #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) coef_i (
        .clk(clk), .rst_n(rst_n), .load(coef_load),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .coef_r(coef_r), .coef_g(coef_g), .coef_b(coef_b)
    );

    assign coef_ch[CH_B] = coef_b;
    assign coef_ch[CH_G] = coef_g;
    assign coef_ch[CH_R] = coef_r;

    // Input register for the pixel word.
    always_ff @(posedge clk) begin
        if (!rst_n)  in_data_q <= '0;
        else if (en) in_data_q <= s_tdata;
    end

    for (genvar p = 0; p < PIX; p++) begin : g_pix
        for (genvar c = 0; c < CH_PER_PIX; c++) begin : g_ch
            localparam int BASE = (p * CH_PER_PIX + c) * COMP_W;
            rgbg_lane #(.COMP_W(COMP_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) lane_i (
                .clk(clk), .rst_n(rst_n), .en(en),
                .comp_i(in_data_q[BASE +: COMP_W]),
                .coef_i(coef_ch[c]),
                .comp_o(m_tdata[BASE +: COMP_W])
            );
        end
    end

    // Pack the flag bits for the matched delay line.
    always_comb begin
        side_in             = '0;
        side_in[SIDE_VALID] = s_tvalid;
        side_in[SIDE_USER]  = s_tuser;
        side_in[SIDE_LAST]  = s_tlast;
    end

    rgbg_side_delay #(.W(SIDE_W), .DEPTH(DEPTH)) side_i (
        .clk(clk), .rst_n(rst_n), .en(en), .d_i(side_in), .d_o(side_out)
    );

    assign m_tvalid = side_out[SIDE_VALID];
    assign m_tuser  = side_out[SIDE_USER];
    assign m_tlast  = side_out[SIDE_LAST];
endmodule

// File: rtl/rgbg_checker.sv
// Module: protocol and timing checks for rgbg_gain_stream, attached by bind.
// Assumes the default latency of three enabled cycles.
module rgbg_checker #(
    parameter int DATA_W = 48,
    parameter int COEF_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tuser,
    input logic              s_tlast,
    input logic              s_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tuser,
    input logic              m_tlast,
    input logic              m_tready,
    input logic [COEF_W-1:0] coef_r,
    input logic [COEF_W-1:0] coef_g,
    input logic [COEF_W-1:0] coef_b
);
    logic [2:0] cyc_q;

    // Count cycles since reset, saturating, to guard the history lookups.
    always_ff @(posedge clk) begin
        if (!rst_n)             cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end

    AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == m_tready); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !m_tready |=> ($stable(m_tdata) && $stable(m_tvalid) && $stable(m_tuser) && $stable(m_tlast))); // R7

    AST_FLAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3 && $past(m_tready) && $past(m_tready, 2) && $past(m_tready, 3))
        |-> (m_tvalid == $past(s_tvalid, 3) && m_tuser == $past(s_tuser, 3) && m_tlast == $past(s_tlast, 3))); // R8

    AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tuser && m_tready) |=> ($stable(coef_r) && $stable(coef_g) && $stable(coef_b))); // R9
endmodule

bind rgbg_gain_stream rgbg_checker #(.DATA_W(DATA_W), .COEF_W(COEF_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tuser(m_tuser),
    .m_tlast(m_tlast), .m_tready(m_tready), .coef_r(coef_r), .coef_g(coef_g), .coef_b(coef_b)
);

// File: tb/rgbg_gain_stream_tb.sv
module rgbg_gain_stream_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] gain_r = 17'd32768, gain_g = 17'd32768, gain_b = 17'd32768;
    logic [47:0] s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
    logic        s_tready;
    logic [47:0] m_tdata;
    logic        m_tvalid, m_tuser, m_tlast;
    logic        m_tready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag = "R4";

    always #10 clk = ~clk;

    rgbg_gain_stream dut_i (
        .clk(clk), .rst_n(rst_n), .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tuser(m_tuser),
        .m_tlast(m_tlast), .m_tready(m_tready)
    );

    typedef struct {bit v; bit u; bit l; logic [47:0] d;} beat_t;
    beat_t pipe[$];
    beat_t exp_b;
    int act_r, act_g, act_b;

    function automatic int scl(int comp, int coef);
        int v = (comp * coef) >>> 15;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic logic [47:0] correct(logic [47:0] d, int cr, int cg, int cb);
        logic [47:0] o;
        for (int p = 0; p < 2; p++) begin
            o[p*24+16 +: 8] = 8'(scl(int'(d[p*24+16 +: 8]), cr));
            o[p*24+8  +: 8] = 8'(scl(int'(d[p*24+8  +: 8]), cg));
            o[p*24    +: 8] = 8'(scl(int'(d[p*24    +: 8]), cb));
        end
        return o;
    endfunction

    // Behavioural reference: a queue standing for the stages still in flight.
    always @(posedge clk) begin
        beat_t nb;
        if (!rst_n) begin
            pipe.delete();
            exp_b = '{0, 0, 0, '0};
            pipe.push_back(exp_b);
            pipe.push_back(exp_b);
            act_r = 32768; act_g = 32768; act_b = 32768;
        end else if (m_tready) begin
            if (s_tvalid && s_tuser) begin
                act_r = int'(gain_r); act_g = int'(gain_g); act_b = int'(gain_b);
            end
            nb.v = s_tvalid; nb.u = s_tuser; nb.l = s_tlast;
            nb.d = correct(s_tdata, act_r, act_g, act_b);
            pipe.push_front(nb);
            exp_b = pipe.pop_back();
        end
    end

    task automatic check(bit ok, string req, string what, logic [47:0] act, logic [47:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
        end
    endtask

    // Compare against the reference a quarter period after each edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check(s_tready == m_tready, "R2", "ready", 48'(s_tready), 48'(m_tready));
            check(m_tvalid == exp_b.v, "R6", "valid", 48'(m_tvalid), 48'(exp_b.v));
            check(m_tuser == exp_b.u && m_tlast == exp_b.l, "R8", "user/last",
                  48'({m_tuser, m_tlast}), 48'({exp_b.u, exp_b.l}));
            check(m_tdata == exp_b.d, tag, "data", m_tdata, exp_b.d);
        end
    end

    // Present a frame of n beats with a given chance of valid and ready, in percent.
    task automatic run_frame(int n, int vpct, int rpct, int chg_at, logic [16:0] nr, logic [16:0] ng, logic [16:0] nb, bit full);
        int sent = 0;
        while (sent < n) begin
            @(negedge clk);
            s_tvalid = ($urandom_range(99) < vpct);
            m_tready = ($urandom_range(99) < rpct);
            s_tuser  = (sent == 0);
            s_tlast  = (sent == n - 1);
            s_tdata  = full ? {$urandom(), $urandom()} | 48'hE0E0E0E0E0E0 : {$urandom(), $urandom()};
            if (sent == chg_at) begin gain_r = nr; gain_g = ng; gain_b = nb; end
            @(posedge clk);
            if (s_tvalid && m_tready) sent++;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state at the outputs
        check(m_tvalid == 1'b0 && m_tuser == 1'b0 && m_tlast == 1'b0, "R1", "flags in reset",
              48'({m_tvalid, m_tuser, m_tlast}), 48'(0));
        check(m_tdata == '0, "R1", "data in reset", m_tdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        m_tready = 1'b1;
        // R1: unity gains before any frame start; valid beats without a frame flag
        tag = "R1";
        repeat (6) begin
            @(negedge clk);
            s_tvalid = 1'b1; s_tdata = {$urandom(), $urandom()};
        end
        @(negedge clk); s_tvalid = 1'b0;
        repeat (4) @(posedge clk);
        // R3 R4: unity pass-through, continuous flow
        tag = "R3 R4";
        run_frame(20, 100, 100, -1, 0, 0, 0, 0);
        // R4: gains above and below unity, with gaps
        tag = "R4";
        gain_r = 17'd49152; gain_g = 17'd32768; gain_b = 17'd12000;
        run_frame(30, 70, 80, -1, 0, 0, 0, 0);
        // R5: full-scale components with the largest gain must clip
        tag = "R5";
        gain_r = 17'd131071; gain_g = 17'd131071; gain_b = 17'd65536;
        run_frame(20, 100, 100, -1, 0, 0, 0, 1);
        // R4: zero gain yields zero
        tag = "R4";
        gain_r = 17'd0; gain_g = 17'd0; gain_b = 17'd0;
        run_frame(10, 100, 100, -1, 0, 0, 0, 0);
        // R9: gain inputs rewritten mid-frame must not take effect until the next frame
        tag = "R9";
        gain_r = 17'd40000; gain_g = 17'd20000; gain_b = 17'd60000;
        run_frame(30, 80, 70, 7, 17'd100000, 17'd5000, 17'd33000, 0);
        run_frame(20, 90, 60, 12, 17'd32768, 17'd32768, 17'd32768, 0);
        // R6 R7: heavy stalls and bubbles, frames back to back
        tag = "R6 R7";
        for (int f = 0; f < 6; f++) begin
            gain_r = 17'($urandom_range(131071)); gain_g = 17'($urandom_range(131071));
            gain_b = 17'($urandom_range(131071));
            run_frame(15 + f, 50, 40, 5, 17'($urandom_range(131071)), 17'd1, 17'd70000, f[0]);
        end
        @(negedge clk); m_tready = 1'b1;
        repeat (6) @(posedge clk);
        #6;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule